// File: doc/BRIEF.md
# Double-Buffered Ten-Bit PWM Generator

This block produces a pulse-width modulated output. The period is set by an 8-bit value. The duty cycle is a 10-bit value: its upper eight bits come from a high duty byte and its two low bits from the top two bits of a low duty byte. The time base is an 8-bit timer with two sub-count bits below it. Those bits advance once per prescaled clock, so the duty resolves to a quarter of one timer step.

A period ends when the timer equals the period value and the sub-count is at its last step. At that point the whole count returns to zero, the output goes active and the buffered duty value is copied into a hidden working register. The output goes inactive when the next count equals the working duty. Duty writes therefore never tear a period. A polarity bit inverts the output. An enable input holds the counters at zero and keeps the output inactive. A one-clock period-match strobe marks each period boundary for surrounding logic.

Top module: `pwm10_gen`

## Requirements
- R1: The duty value D is `{duty_hi[7:0], duty_lo[7:6]}` (10 bits). Bits 5:0 of `duty_lo` have no effect on the output.
- R2: While enabled, the 10-bit count advances by one per prescaled tick. One period spans (period+1)*4 counts. After the last count the timer and sub-count both return to zero.
- R3: `prescale_sel` selects the tick rate: 0 gives divide by 1, 1 gives divide by 4, 2 gives divide by 16 and 3 gives divide by 64. A period therefore lasts (period+1)*4*divisor clocks.
- R4: With polarity 0, `pwm_out` is 1 for the first D counts of each period and 0 for the rest.
- R5: When the working duty is 0, the output stays inactive for the whole period.
- R6: When the working duty is at least (period+1)*4, the output stays active for the whole period.
- R7: A change to the duty inputs takes effect at the next period boundary. The period in progress keeps the previously latched value.
- R8: With `polarity`=1 the output is inverted, so the inactive level equals the value of `polarity`.
- R9: When `enable` is sampled low, the counters clear and `pwm_out` shows the inactive level from the next clock on. The first clock edge that samples `enable` high loads the working duty from the inputs, starts the output for that duty, and holds the count at 0. A full period then follows.
- R10: Synchronous active-low reset clears all state. `pwm_out` then shows the inactive level and `period_match` is 0.
- R11: `period_match` is high for exactly the one clock whose edge ends a period, and never on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module run enable |
| polarity | input | 1 | 1 inverts the output |
| prescale_sel | input | 2 | Tick divider select: 0 = /1, 1 = /4, 2 = /16, 3 = /64 |
| period | input | 8 | Period value compared with the timer |
| duty_hi | input | 8 | Upper eight duty bits |
| duty_lo | input | 8 | Bits 7:6 are the two low duty bits; bits 5:0 are unused |
| pwm_out | output | 1 | Modulated output after polarity |
| period_match | output | 1 | One-clock strobe at each period boundary |

## Verification
The modulator is driven with several mid-range duty values, and each run measures the period length and the active time. These runs separate the 8-bit period compare from the 10-bit duty compare, and a high byte of the duty from its two low bits. Duty zero, duty equal to the span, and the largest duty test the two saturating ends. A duty change made early in a period tests the shadow register: the current period must keep the old width. Runs at every divider setting, with inverted polarity, and through a disable and re-enable show that the divider, the inversion and the restart sequence each act independently of the comparators.

// File: rtl/pwm10_pkg.sv
// Shared definitions for the ten-bit PWM generator.
// Assumes the divider select is two bits and each step multiplies by four.
package pwm10_pkg;
    localparam int PRE_SEL_W = 2;
    localparam int PRE_STEP  = 2;   // log2 of the ratio between adjacent divider settings

    typedef enum logic [PRE_SEL_W-1:0] {
        PRE_DIV1  = 2'd0,
        PRE_DIV4  = 2'd1,
        PRE_DIV16 = 2'd2,
        PRE_DIV64 = 2'd3
    } prescale_e;
endpackage

// File: rtl/pwm10_prescaler.sv
// Tick generator for the PWM time base.
// It emits one tick every 4**sel clocks while run is high. The counter
// stays at zero while run is low. The limit compare uses >=, so changing
// the divider select in mid-count can never stall the tick.
module pwm10_prescaler
    import pwm10_pkg::*;
#(
    parameter int SEL_W = PRE_SEL_W,
    parameter int STEP  = PRE_STEP
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  prescale_e sel,
    output logic      tick
);
    localparam int CNT_W = STEP * ((1 << SEL_W) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   div_w;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected divider.
    always_comb begin
        div_w = (CNT_W+1)'(1) << (STEP * int'(sel));
        limit = CNT_W'(div_w - (CNT_W+1)'(1));
    end

    assign tick = run && (cnt >= limit);

    // Divider counter: restarts on a tick, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwm10_timebase.sv
// Extended time base: a timer with sub-count bits below it.
// The sub-count advances on each tick, and the timer advances on the carry
// out of the sub-count. The period ends when the timer equals the period
// value and the sub-count is all ones; the whole count then returns to zero.
// The count is held at zero while run is low.
module pwm10_timebase #(
    parameter int TMR_W  = 8,
    parameter int FRAC_W = 2,
    localparam int TB_W  = TMR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [TMR_W-1:0]  period,
    output logic [TMR_W-1:0]  tmr,
    output logic [FRAC_W-1:0] frac,
    output logic [TB_W-1:0]   tb_next,
    output logic              wrap
);
    assign wrap    = run && tick && (tmr == period) && (&frac);
    assign tb_next = {tmr, frac} + TB_W'(1);

    // Count register: cleared at the period end, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tmr  <= '0;
            frac <= '0;
        end else if (wrap) begin
            tmr  <= '0;
            frac <= '0;
        end else if (tick) begin
            {tmr, frac} <= tb_next;
        end
    end
endmodule

// File: rtl/pwm10_duty_shadow.sv
// Working duty register. It is invisible from outside the block.
// It captures the buffered duty only on a load strobe, which is the
// period end or the start of a run.
module pwm10_duty_shadow #(
    parameter int TB_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TB_W-1:0] duty_buf,
    output logic [TB_W-1:0] wduty
);
    // Capture the buffered duty on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wduty <= '0;
        end else if (load) begin
            wduty <= duty_buf;
        end
    end
endmodule

// File: rtl/pwm10_out_latch.sv
// Set/reset output stage with polarity.
// A set has priority over a clear. The value written by a set already
// accounts for a zero duty. The latch is cleared while the block is disabled.
module pwm10_out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_req,
    input  logic set_val,
    input  logic clr_req,
    input  logic polarity,
    output logic q,
    output logic pwm_out
);
    // Latch update: cleared while disabled, set at a boundary, cleared at the duty match.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            q <= 1'b0;
        end else if (set_req) begin
            q <= set_val;
        end else if (clr_req) begin
            q <= 1'b0;
        end
    end

    assign pwm_out = q ^ polarity;
endmodule

// File: rtl/pwm10_gen.sv
// Double-buffered ten-bit PWM generator, top level.
// The period is compared at timer width. The duty is compared against the
// extended count of the clock edge that is about to happen. The output
// register therefore stays active for exactly the first D counts of a period.
// All inputs are assumed synchronous to clk.
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FRAC_W = 2,
    parameter int DLO_W  = 8,
    localparam int TB_W  = TMR_W + FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 polarity,
    input  logic [PRE_SEL_W-1:0] prescale_sel,
    input  logic [TMR_W-1:0]     period,
    input  logic [TMR_W-1:0]     duty_hi,
    input  logic [DLO_W-1:0]     duty_lo,
    output logic                 pwm_out,
    output logic                 period_match
);
    logic              en_q;
    logic              start;
    logic              run;
    logic              tick;
    logic [TMR_W-1:0]  tmr;
    logic [FRAC_W-1:0] frac;
    logic [TB_W-1:0]   tb_next;
    logic              wrap;
    logic [TB_W-1:0]   duty_buf;
    logic [TB_W-1:0]   wduty;
    logic              latch_q;
    logic              clr_req;
    logic              unused_lo;

    // The low duty bits sit at the top of the low byte; the rest are unused.
    assign duty_buf  = {duty_hi, duty_lo[DLO_W-1 -: FRAC_W]};
    assign unused_lo = ^duty_lo[DLO_W-FRAC_W-1:0];

    // Enable history: it marks the first enabled clock as the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
        end
    end

    assign start   = enable && !en_q;
    assign run     = enable && en_q;
    assign clr_req = run && tick && !wrap && (tb_next == wduty);

    pwm10_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (prescale_e'(prescale_sel)),
        .tick  (tick)
    );

    pwm10_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .period  (period),
        .tmr     (tmr),
        .frac    (frac),
        .tb_next (tb_next),
        .wrap    (wrap)
    );

    pwm10_duty_shadow #(.TB_W(TB_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start || wrap),
        .duty_buf (duty_buf),
        .wduty    (wduty)
    );

    pwm10_out_latch u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .set_req  (start || wrap),
        .set_val  (duty_buf != '0),
        .clr_req  (clr_req),
        .polarity (polarity),
        .q        (latch_q),
        .pwm_out  (pwm_out)
    );

    assign period_match = wrap;
endmodule

// File: rtl/pwm10_gen_chk.sv
// Assertion checker for pwm10_gen. It is attached by the bind at the end of this file.
module pwm10_gen_chk #(
    parameter int TMR_W  = 8,
    parameter int FRAC_W = 2,
    localparam int TB_W  = TMR_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              polarity,
    input logic              pwm_out,
    input logic              period_match,
    input logic              en_q,
    input logic [TB_W-1:0]   wduty,
    input logic              latch_q,
    input logic [TMR_W-1:0]  tmr,
    input logic [FRAC_W-1:0] frac
);
    // R11: the boundary strobe never lasts two clocks.
    p_match_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        period_match |=> !period_match);

    // R2: the count restarts from zero after a boundary.
    p_match_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_match |=> (tmr == '0 && frac == '0));

    // R9: one clock after enable is seen low, the output shows the inactive level.
    p_off_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> (pwm_out == polarity));

    // R5: a zero working duty never leaves the latch set.
    p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && wduty == '0) |-> !latch_q);

    // R7: the working duty changes only at a boundary or at the start of a run.
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$past(period_match)) |-> $stable(wduty));
endmodule

bind pwm10_gen pwm10_gen_chk #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .polarity     (polarity),
    .pwm_out      (pwm_out),
    .period_match (period_match),
    .en_q         (en_q),
    .wduty        (wduty),
    .latch_q      (latch_q),
    .tmr          (tmr),
    .frac         (frac)
);

// File: tb/tb_pwm10_gen.sv
`timescale 1ns/1ps
module tb_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       polarity = 1'b0;
    logic [1:0] prescale_sel = 2'd0;
    logic [7:0] period = 8'd0;
    logic [7:0] duty_hi = 8'd0;
    logic [7:0] duty_lo = 8'd0;
    logic       pwm_out;
    logic       period_match;

    int    n_run = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // Behavioural reference state
    int m_pc = 0, m_cnt = 0, m_wd = 0;
    bit m_q = 0, m_enq = 0;

    always #2.5 clk = ~clk;

    pwm10_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .polarity(polarity),
        .prescale_sel(prescale_sel), .period(period), .duty_hi(duty_hi),
        .duty_lo(duty_lo), .pwm_out(pwm_out), .period_match(period_match)
    );

    function automatic int f_div();
        return 1 << (2 * int'(prescale_sel));
    endfunction
    function automatic int f_span();
        return (int'(period) + 1) * 4;
    endfunction
    function automatic int f_duty();   // R1 composition
        return int'(duty_hi) * 4 + int'(duty_lo[7:6]);
    endfunction

    // Reference model: advanced once per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_cnt = 0; m_wd = 0; m_q = 0; m_enq = 0;
        end else if (!enable) begin
            m_enq = 0; m_pc = 0; m_cnt = 0; m_q = 0;
        end else if (!m_enq) begin
            m_enq = 1; m_pc = 0; m_cnt = 0;
            m_wd = f_duty(); m_q = (m_wd != 0);
        end else begin
            bit tk;
            tk = (m_pc >= f_div() - 1);
            m_pc = tk ? 0 : m_pc + 1;
            if (tk) begin
                if (m_cnt == f_span() - 1) begin
                    m_cnt = 0; m_wd = f_duty(); m_q = (m_wd != 0);
                end else begin
                    m_cnt = (m_cnt + 1) % 1024;
                    if (m_cnt == m_wd) m_q = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && chk_on && !done) begin
            bit e_pm, e_out;
            e_pm  = enable && m_enq && (m_pc >= f_div() - 1) && (m_cnt == f_span() - 1);
            e_out = m_q ^ polarity;
            check(pwm_out == e_out, cur_req, "per-clock pwm_out", int'(pwm_out), int'(e_out));
            check(period_match == e_pm, cur_req, "per-clock period_match",
                  int'(period_match), int'(e_pm));
        end
    end

    // Input changes are made just after a rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_pm();
        for (int g = 0; g < 60000; g++) begin
            @(negedge clk);
            if (period_match) return;
        end
    endtask

    // Counts clocks and raw high samples up to and including the next strobe
    task automatic measure(input bit wait_first, output int len, output int ones);
        if (wait_first) wait_pm();
        len = 0; ones = 0;
        for (int g = 0; g < 60000; g++) begin
            @(negedge clk);
            len++;
            if (pwm_out) ones++;
            if (period_match) return;
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int len, ones;
        repeat (4) step();
        @(negedge clk);
        check(pwm_out == 1'b0, "R10", "reset pwm_out", int'(pwm_out), 0);
        check(period_match == 1'b0, "R10", "reset period_match", int'(period_match), 0);
        rst_n = 1'b1; chk_on = 1'b1;
        step();
        cur_req = "R8"; polarity = 1'b1; step(); @(negedge clk);
        check(pwm_out == 1'b1, "R8", "disabled level with polarity 1", int'(pwm_out), 1);
        polarity = 1'b0;

        // R4 / R1 / R2: period 9 (span 40), duty {5,2} = 22, junk in the unused low bits
        cur_req = "R4"; step();
        period = 8'd9; duty_hi = 8'd5; duty_lo = 8'hBF; enable = 1'b1;
        measure(1, len, ones);
        check(len == 40, "R2", "period length", len, 40);
        check(ones == 22, "R4", "active clocks", ones, 22);
        cur_req = "R1"; step(); duty_lo = 8'h80;
        measure(1, len, ones);
        check(ones == 22, "R1", "unused low bits ignored", ones, 22);
        step(); duty_lo = 8'h3F;
        measure(1, len, ones);
        check(ones == 20, "R1", "low two bits zero", ones, 20);

        // R7: change early in a period; the current period keeps duty 20
        cur_req = "R7";
        wait_pm(); step(); duty_hi = 8'd2; duty_lo = 8'h40;
        measure(0, len, ones);
        check(ones == 20, "R7", "old duty kept in current period", ones, 20);
        measure(0, len, ones);
        check(ones == 9, "R7", "new duty at next boundary", ones, 9);

        // R5 / R6: the saturating ends
        cur_req = "R5"; step(); duty_hi = 8'd0; duty_lo = 8'h00;
        measure(1, len, ones);
        check(ones == 0, "R5", "zero duty", ones, 0);
        cur_req = "R6"; step(); duty_hi = 8'd10;
        measure(1, len, ones);
        check(ones == 40, "R6", "duty equal to span", ones, 40);
        step(); duty_hi = 8'hFF; duty_lo = 8'hC0;
        measure(1, len, ones);
        check(ones == 40, "R6", "maximum duty", ones, 40);

        // R9: disable, reprogram, then a clean first period after enable
        cur_req = "R9"; step(); enable = 1'b0;
        step(); @(negedge clk);
        check(pwm_out == 1'b0, "R9", "output after disable", int'(pwm_out), 0);
        period = 8'd1; duty_hi = 8'd1; duty_lo = 8'h40;
        repeat (3) step();
        enable = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R9", "before start edge", int'(pwm_out), 0);
        measure(0, len, ones);
        check(len == 8, "R9", "first period length", len, 8);
        check(ones == 5, "R9", "first period duty from buffer", ones, 5);

        // R3: every divider setting with span 8 and duty 3
        cur_req = "R3"; step(); duty_hi = 8'd0; duty_lo = 8'hC0;
        for (int s = 1; s < 4; s++) begin
            step(); prescale_sel = 2'(s);
            measure(1, len, ones);
            check(len == 8 * (1 << (2 * s)), "R3", "prescaled period", len, 8 * (1 << (2 * s)));
            check(ones == 3 * (1 << (2 * s)), "R3", "prescaled duty", ones, 3 * (1 << (2 * s)));
        end

        // R8: inverted output at divide by 1
        cur_req = "R8"; step(); prescale_sel = 2'd0; polarity = 1'b1;
        measure(1, len, ones);
        check(ones == 5, "R8", "high clocks when inverted", ones, 5);

        // R2: shortest period (span 4) with duty 2
        cur_req = "R2"; step(); polarity = 1'b0; enable = 1'b0;
        step(); period = 8'd0; duty_hi = 8'd0; duty_lo = 8'h80; enable = 1'b1;
        measure(1, len, ones);
        check(len == 4, "R2", "period 0 length", len, 4);
        check(ones == 2, "R11", "period 0 duty", ones, 2);
        measure(0, len, ones);
        check(len == 4, "R11", "back-to-back strobes spaced", len, 4);

        // R10: reset while running
        cur_req = "R10"; step(); rst_n = 1'b0; chk_on = 1'b0;
        step(); @(negedge clk);
        check(pwm_out == 1'b0 && period_match == 1'b0, "R10", "reset while running",
              int'({pwm_out, period_match}), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule